// File: doc/BRIEF.md
# UART Interrupt Priority Identification

This block sits beside the receiver, transmitter and modem-status logic of a 16550-style serial channel. It collects five interrupt causes: receiver line status, received data (or FIFO trigger level), character timeout, transmitter holding register empty and modem status. It masks each cause with its enable bit, picks the most urgent one and presents it as a read-only identification byte. It also drives one interrupt line toward the host, gated by the OUT2 bit of the modem control register.

Line-status and modem-status causes arrive as single-cycle event pulses. The block holds each one until the matching status register is read. Received data and character timeout arrive as levels from the receive path, which handles their clearing. The transmitter-empty cause is kept inside the block. It is raised by the transmitter becoming empty, by its enable going from 0 to 1 while empty, or by FIFO mode being switched on with the enable set. It is cleared by a write to the transmit holding register, or by a completed read of the identification byte that reported it.

While the host holds the identification read strobe, the byte it sees does not change. Events that arrive during the read are still latched and show up once the strobe drops.

Top module: `uirq_ident_unit`

## Requirements
- R1: The enable register resets to 0x00. A write stores data bits 3:0 (bit 0 received data and timeout, bit 1 transmitter empty, bit 2 line status, bit 3 modem status). Bits 7:4 always read 0.
- R2: Identification bit 0 is 0 when an enabled cause is pending and 1 when none is. With none pending, bits 3:1 are 000. After reset the byte reads 0x01.
- R3: Bits 3:1 carry the highest-priority enabled cause, in this order: line status 011, then received data 010, then character timeout 110, then transmitter empty 001, then modem status 000. When received data and timeout are both present, received data is reported.
- R4: A cause whose enable bit is 0 is never reported and never drives the interrupt line.
- R5: Bits 7 and 6 both equal the FIFO-mode input and bits 5:4 read 0. Character timeout is reported only in FIFO mode, so bit 3 is 0 outside FIFO mode.
- R6: While the read strobe is high, the identification byte holds the value it had on the cycle the strobe was first seen. Causes that arrive during the read are latched and appear on the cycle after the strobe falls.
- R7: The transmitter-empty cause clears on a transmit-holding write. It also clears when a read completes whose held byte was 0x?2 in bits 3:0 (transmitter empty reported). A completed read that reported another cause leaves it pending.
- R8: The transmitter-empty cause is raised when the transmitter-empty level rises. It is also raised when its enable goes 0 to 1 while the level is high, and when FIFO mode rises with the enable set and the level high.
- R9: Line-status and modem-status causes are set by their event pulse and cleared by their status-read pulse. An event in the same cycle as a read leaves the cause set.
- R10: The interrupt output is high exactly when, on the previous cycle, an enabled cause was pending and OUT2 was 1.
- R11: Outside a read, the identification byte shows the pending state of the previous cycle (one register stage). A latched cause therefore appears two cycles after its event pulse, and a level cause one cycle after its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ier_we | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Enable register write data |
| ier_rdata | output | 8 | Enable register read value |
| fifo_mode | input | 1 | FIFO mode active level |
| out2_en | input | 1 | OUT2 bit of modem control, global interrupt gate |
| ls_event | input | 1 | Receiver line error/break event pulse |
| ls_status_rd | input | 1 | Line status register read pulse |
| rx_ready | input | 1 | Received data available / trigger level reached |
| rx_timeout | input | 1 | Receive character timeout level |
| thr_empty | input | 1 | Transmit holding register (or FIFO) empty level |
| thr_wr | input | 1 | Transmit holding register write pulse |
| ms_event | input | 1 | Modem input change event pulse |
| ms_status_rd | input | 1 | Modem status register read pulse |
| iir_rd | input | 1 | Identification register read strobe, high for the whole access |
| iir_rdata | output | 8 | Identification byte |
| irq | output | 1 | Registered interrupt request, active high |

## Verification
The bench targets the freeze window. An event arrives in the middle of a multi-cycle read, and it must neither change the byte being read nor be lost once the read ends. A design without the freeze would return a changing byte, and one that drops captures would miss the line-status event. The bench also checks that a completed read clears the transmitter-empty cause only when that cause was the one reported. A wrong design would either leave the interrupt stuck after a transmit-empty read or quietly swallow a transmit-empty cause hidden behind line status. Finally it covers the three re-arm paths of the transmitter-empty cause, and the rule that character timeout loses to received data and is hidden outside FIFO mode; a faulty encoder would show 0xCC instead of 0xC4, or a set bit 3 in plain mode.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    localparam int REG_W   = 8;
    localparam int EN_W    = 4;
    localparam int CODE_W  = 3;

    typedef enum logic [CODE_W-1:0] {
        ID_MSR = 3'b000,
        ID_THR = 3'b001,
        ID_RXD = 3'b010,
        ID_LSR = 3'b011,
        ID_CTO = 3'b110
    } id_code_e;

    // Enable field, packed so its bit order matches enable register bits 3:0.
    typedef struct packed {
        logic msr;
        logic lsr;
        logic thr;
        logic rxd;
    } irq_en_t;

    // Raw cause levels feeding the priority selector.
    typedef struct packed {
        logic lsr;
        logic rxd;
        logic cto;
        logic thr;
        logic msr;
    } irq_src_t;

    typedef struct packed {
        logic     pend;
        id_code_e code;
    } irq_pick_t;

    function automatic logic sticky_next(input logic cur, input logic set,
                                         input logic clr);
        return set | (cur & ~clr);
    endfunction

    function automatic logic [REG_W-1:0] pack_ident(input logic fifo,
                                                    input irq_pick_t pick);
        return {fifo, fifo, 2'b00, pick.code, ~pick.pend};
    endfunction

endpackage

// File: rtl/uirq_enable_reg.sv
module uirq_enable_reg
    import uirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output irq_en_t          en,
    output logic [REG_W-1:0] rdata,
    output logic             thr_arm
);
    localparam int PAD_W = REG_W - EN_W;

    irq_en_t en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (we) begin
            en_q <= irq_en_t'(wdata[EN_W-1:0]);
        end
    end

    // Transmit-empty enable going 0 -> 1 on this write.
    assign thr_arm = we & wdata[1] & ~en_q.thr;
    assign en      = en_q;
    assign rdata   = {{PAD_W{1'b0}}, en_q};

    logic unused_hi;
    assign unused_hi = ^wdata[REG_W-1:EN_W];

endmodule

// File: rtl/uirq_src_latch.sv
module uirq_src_latch
    import uirq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ls_event,
    input  logic ls_clr,
    input  logic ms_event,
    input  logic ms_clr,
    input  logic thr_empty,
    input  logic thr_wr,
    input  logic thr_rd_clr,
    input  logic thr_arm,
    input  logic thr_en,
    input  logic fifo_mode,
    output logic ls_pend,
    output logic ms_pend,
    output logic thr_pend
);
    logic ls_q, ms_q, thr_q;
    logic empty_q, fifo_q;
    logic thr_set, thr_clr;

    always_comb begin
        thr_set = (thr_empty & ~empty_q)
                | (thr_arm & thr_empty)
                | (fifo_mode & ~fifo_q & thr_en & thr_empty);
        thr_clr = thr_wr | thr_rd_clr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ls_q    <= 1'b0;
            ms_q    <= 1'b0;
            thr_q   <= 1'b0;
            empty_q <= 1'b1;
            fifo_q  <= 1'b0;
        end else begin
            ls_q    <= sticky_next(ls_q, ls_event, ls_clr);
            ms_q    <= sticky_next(ms_q, ms_event, ms_clr);
            thr_q   <= sticky_next(thr_q, thr_set, thr_clr);
            empty_q <= thr_empty;
            fifo_q  <= fifo_mode;
        end
    end

    assign ls_pend  = ls_q;
    assign ms_pend  = ms_q;
    assign thr_pend = thr_q;

endmodule

// File: rtl/uirq_prio.sv
module uirq_prio
    import uirq_pkg::*;
(
    input  irq_en_t   en,
    input  logic      fifo_mode,
    input  logic      ls_pend,
    input  logic      rx_ready,
    input  logic      rx_timeout,
    input  logic      thr_pend,
    input  logic      ms_pend,
    output irq_pick_t pick
);
    irq_src_t act;

    always_comb begin
        act.lsr = ls_pend  & en.lsr;
        act.rxd = rx_ready & en.rxd;
        act.cto = rx_timeout & en.rxd & fifo_mode;
        act.thr = thr_pend & en.thr;
        act.msr = ms_pend  & en.msr;
    end

    always_comb begin
        pick.pend = 1'b1;
        if (act.lsr)      pick.code = ID_LSR;
        else if (act.rxd) pick.code = ID_RXD;
        else if (act.cto) pick.code = ID_CTO;
        else if (act.thr) pick.code = ID_THR;
        else begin
            pick.code = ID_MSR;
            pick.pend = act.msr;
        end
    end

endmodule

// File: rtl/uirq_ident_view.sv
module uirq_ident_view
    import uirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             iir_rd,
    input  logic             fifo_mode,
    input  logic             out2_en,
    input  irq_pick_t        pick,
    output logic [REG_W-1:0] iir_rdata,
    output logic             irq,
    output logic             thr_rd_clr
);
    localparam logic [3:0] THR_LOW = {ID_THR, 1'b0};
    localparam logic [REG_W-1:0] IDLE_ID = {{(REG_W-1){1'b0}}, 1'b1};

    logic             rd_q;
    logic             irq_q;
    logic [REG_W-1:0] id_q;
    logic [REG_W-1:0] live_id;

    assign live_id = pack_ident(fifo_mode, pick);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= 1'b0;
            irq_q <= 1'b0;
            id_q  <= IDLE_ID;
        end else begin
            rd_q  <= iir_rd;
            irq_q <= pick.pend & out2_en;
            if (!iir_rd) begin
                id_q <= live_id;
            end
        end
    end

    // Access finished and the held byte named transmit-empty.
    assign thr_rd_clr = rd_q & ~iir_rd & (id_q[3:0] == THR_LOW);
    assign iir_rdata  = id_q;
    assign irq        = irq_q;

endmodule

// File: rtl/uirq_ident_unit.sv
module uirq_ident_unit
    import uirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ier_we,
    input  logic [REG_W-1:0] ier_wdata,
    output logic [REG_W-1:0] ier_rdata,
    input  logic             fifo_mode,
    input  logic             out2_en,
    input  logic             ls_event,
    input  logic             ls_status_rd,
    input  logic             rx_ready,
    input  logic             rx_timeout,
    input  logic             thr_empty,
    input  logic             thr_wr,
    input  logic             ms_event,
    input  logic             ms_status_rd,
    input  logic             iir_rd,
    output logic [REG_W-1:0] iir_rdata,
    output logic             irq
);
    irq_en_t   en;
    irq_pick_t pick;
    logic      thr_arm;
    logic      thr_rd_clr;
    logic      ls_pend, ms_pend, thr_pend;

    uirq_enable_reg u_en (
        .clk     (clk),
        .rst     (rst),
        .we      (ier_we),
        .wdata   (ier_wdata),
        .en      (en),
        .rdata   (ier_rdata),
        .thr_arm (thr_arm)
    );

    uirq_src_latch u_src (
        .clk        (clk),
        .rst        (rst),
        .ls_event   (ls_event),
        .ls_clr     (ls_status_rd),
        .ms_event   (ms_event),
        .ms_clr     (ms_status_rd),
        .thr_empty  (thr_empty),
        .thr_wr     (thr_wr),
        .thr_rd_clr (thr_rd_clr),
        .thr_arm    (thr_arm),
        .thr_en     (en.thr),
        .fifo_mode  (fifo_mode),
        .ls_pend    (ls_pend),
        .ms_pend    (ms_pend),
        .thr_pend   (thr_pend)
    );

    uirq_prio u_prio (
        .en         (en),
        .fifo_mode  (fifo_mode),
        .ls_pend    (ls_pend),
        .rx_ready   (rx_ready),
        .rx_timeout (rx_timeout),
        .thr_pend   (thr_pend),
        .ms_pend    (ms_pend),
        .pick       (pick)
    );

    uirq_ident_view u_view (
        .clk        (clk),
        .rst        (rst),
        .iir_rd     (iir_rd),
        .fifo_mode  (fifo_mode),
        .out2_en    (out2_en),
        .pick       (pick),
        .iir_rdata  (iir_rdata),
        .irq        (irq),
        .thr_rd_clr (thr_rd_clr)
    );

endmodule

// File: rtl/uirq_ident_chk.sv
module uirq_ident_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] ier_rdata,
    input logic       iir_rd,
    input logic [7:0] iir_rdata,
    input logic       out2_en,
    input logic       irq,
    input logic       ls_event,
    input logic       ls_status_rd,
    input logic       ls_pend
);
    assert_ier_upper_zero_R1: assert property (@(posedge clk) disable iff (rst)
        ier_rdata[7:4] == 4'h0);

    assert_idle_code_R2: assert property (@(posedge clk) disable iff (rst)
        iir_rdata[0] |-> iir_rdata[3:1] == 3'b000);

    assert_fifo_bits_R5: assert property (@(posedge clk) disable iff (rst)
        (iir_rdata[7] == iir_rdata[6]) && (iir_rdata[5:4] == 2'b00));

    assert_no_timeout_plain_R5: assert property (@(posedge clk) disable iff (rst)
        !iir_rdata[7] |-> !iir_rdata[3]);

    assert_freeze_R6: assert property (@(posedge clk) disable iff (rst)
        $past(iir_rd) |-> $stable(iir_rdata));

    assert_ls_capture_R9: assert property (@(posedge clk) disable iff (rst)
        $past(ls_event) |-> ls_pend);

    assert_ls_hold_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(ls_pend) && !$past(ls_status_rd)) |-> ls_pend);

    assert_out2_gate_R10: assert property (@(posedge clk) disable iff (rst)
        !$past(out2_en) |-> !irq);

endmodule

bind uirq_ident_unit uirq_ident_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .ier_rdata    (ier_rdata),
    .iir_rd       (iir_rd),
    .iir_rdata    (iir_rdata),
    .out2_en      (out2_en),
    .irq          (irq),
    .ls_event     (ls_event),
    .ls_status_rd (ls_status_rd),
    .ls_pend      (ls_pend)
);

// File: tb/uirq_ident_unit_bench.sv
`timescale 1ns/1ps
module uirq_ident_unit_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ier_we = 1'b0;
    logic [7:0] ier_wdata = 8'h00;
    logic [7:0] ier_rdata;
    logic       fifo_mode = 1'b0;
    logic       out2_en = 1'b0;
    logic       ls_event = 1'b0;
    logic       ls_status_rd = 1'b0;
    logic       rx_ready = 1'b0;
    logic       rx_timeout = 1'b0;
    logic       thr_empty = 1'b0;
    logic       thr_wr = 1'b0;
    logic       ms_event = 1'b0;
    logic       ms_status_rd = 1'b0;
    logic       iir_rd = 1'b0;
    logic [7:0] iir_rdata;
    logic       irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    uirq_ident_unit u_uirq_ident_unit (
        .clk(clk), .rst(rst), .ier_we(ier_we), .ier_wdata(ier_wdata),
        .ier_rdata(ier_rdata), .fifo_mode(fifo_mode), .out2_en(out2_en),
        .ls_event(ls_event), .ls_status_rd(ls_status_rd), .rx_ready(rx_ready),
        .rx_timeout(rx_timeout), .thr_empty(thr_empty), .thr_wr(thr_wr),
        .ms_event(ms_event), .ms_status_rd(ms_status_rd), .iir_rd(iir_rd),
        .iir_rdata(iir_rdata), .irq(irq)
    );

    // Reference state, updated from the requirements at each edge.
    logic [7:0] m_ier, m_id;
    logic       m_ls, m_ms, m_thr, m_empty_q, m_fifo_q, m_rd_q, m_irq;

    function automatic logic [7:0] exp_ident(input logic [7:0] en, input logic ls,
            input logic rx, input logic to, input logic thr, input logic ms,
            input logic fifo);
        logic [2:0] c;
        logic p;
        p = 1'b1;
        c = 3'b000;
        if (ls & en[2])             c = 3'b011;
        else if (rx & en[0])        c = 3'b010;
        else if (to & en[0] & fifo) c = 3'b110;
        else if (thr & en[1])       c = 3'b001;
        else if (ms & en[3])        c = 3'b000;
        else                        p = 1'b0;
        return {fifo, fifo, 2'b00, c, ~p};
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        logic [7:0] live, n_ier, n_id;
        logic n_ls, n_ms, n_thr, n_irq, set_t, clr_t, done_rd;
        live    = exp_ident(m_ier, m_ls, rx_ready, rx_timeout, m_thr, m_ms, fifo_mode);
        n_ier   = ier_we ? {4'h0, ier_wdata[3:0]} : m_ier;
        n_id    = iir_rd ? m_id : live;
        n_irq   = ~live[0] & out2_en;
        done_rd = m_rd_q & ~iir_rd;
        set_t   = (thr_empty & ~m_empty_q) | (ier_we & ier_wdata[1] & ~m_ier[1] & thr_empty)
                | (fifo_mode & ~m_fifo_q & m_ier[1] & thr_empty);
        clr_t   = thr_wr | (done_rd & (m_id[3:0] == 4'h2));
        n_thr   = set_t | (m_thr & ~clr_t);
        n_ls    = ls_event | (m_ls & ~ls_status_rd);
        n_ms    = ms_event | (m_ms & ~ms_status_rd);
        @(posedge clk);
        #1;
        if (rst) begin
            m_ier = 8'h00; m_id = 8'h01; m_ls = 0; m_ms = 0; m_thr = 0;
            m_empty_q = 1; m_fifo_q = 0; m_rd_q = 0; m_irq = 0;
        end else begin
            m_empty_q = thr_empty; m_fifo_q = fifo_mode; m_rd_q = iir_rd;
            m_ier = n_ier; m_id = n_id; m_ls = n_ls; m_ms = n_ms;
            m_thr = n_thr; m_irq = n_irq;
            chk("R1 enable readback", ier_rdata, m_ier);
            chk("R3 identification", iir_rdata, m_id);
            chk("R10 irq", {7'h0, irq}, {7'h0, m_irq});
        end
    endtask

    task automatic wr_ier(input logic [7:0] v);
        ier_we = 1'b1; ier_wdata = v;
        tick();
        ier_we = 1'b0;
    endtask

    initial begin
        int rd_left;
        int seed;
        seed = $urandom(32'h5eed_0107);
        repeat (3) tick();
        rst = 1'b0;
        // Reset state
        chk("R1 reset enable", ier_rdata, 8'h00);
        chk("R2 reset ident", iir_rdata, 8'h01);
        chk("R10 reset irq", {7'h0, irq}, 8'h00);
        tick();

        wr_ier(8'hFF);
        chk("R1 upper bits zero", ier_rdata, 8'h0F);

        // R8 empty rise, R10 gated by OUT2
        thr_empty = 1'b1;
        tick();
        tick();
        chk("R8 empty rise", iir_rdata, 8'h02);
        chk("R10 out2 low", {7'h0, irq}, 8'h00);
        out2_en = 1'b1;
        tick();
        chk("R10 out2 high", {7'h0, irq}, 8'h01);

        // R3 modem below transmit
        ms_event = 1'b1; tick(); ms_event = 1'b0; tick();
        chk("R3 tx over modem", iir_rdata, 8'h02);
        // R9 / R11 line status latency
        ls_event = 1'b1; tick(); ls_event = 1'b0;
        chk("R11 one-cycle lag", iir_rdata, 8'h02);
        tick();
        chk("R9 line status set", iir_rdata, 8'h06);
        rx_ready = 1'b1; tick();
        chk("R3 line status top", iir_rdata, 8'h06);
        ls_status_rd = 1'b1; tick(); ls_status_rd = 1'b0; tick();
        chk("R9 line status cleared", iir_rdata, 8'h04);
        rx_ready = 1'b0; tick();
        chk("R3 back to tx", iir_rdata, 8'h02);

        // R6 freeze with event during read, R7 clear by read
        iir_rd = 1'b1; ls_event = 1'b1; tick(); ls_event = 1'b0;
        chk("R6 frozen 1", iir_rdata, 8'h02);
        tick(); chk("R6 frozen 2", iir_rdata, 8'h02);
        tick(); chk("R6 frozen 3", iir_rdata, 8'h02);
        iir_rd = 1'b0; tick();
        chk("R6 event after read", iir_rdata, 8'h06);
        ls_status_rd = 1'b1; tick(); ls_status_rd = 1'b0; tick();
        chk("R7 read cleared tx", iir_rdata, 8'h00);
        ms_status_rd = 1'b1; tick(); ms_status_rd = 1'b0; tick();
        chk("R9 modem cleared", iir_rdata, 8'h01);
        chk("R10 irq idle", {7'h0, irq}, 8'h00);

        // R7 read reporting another cause keeps tx pending
        thr_empty = 1'b0; tick();
        thr_empty = 1'b1; ls_event = 1'b1; tick(); ls_event = 1'b0; tick();
        chk("R7 line status shown", iir_rdata, 8'h06);
        iir_rd = 1'b1; tick(); iir_rd = 1'b0; tick();
        ls_status_rd = 1'b1; tick(); ls_status_rd = 1'b0; tick();
        chk("R7 tx kept", iir_rdata, 8'h02);
        thr_wr = 1'b1; tick(); thr_wr = 1'b0; tick();
        chk("R7 write cleared tx", iir_rdata, 8'h01);

        // R8 enable re-arm
        wr_ier(8'h00);
        wr_ier(8'h0F);
        tick();
        chk("R8 enable rise", iir_rdata, 8'h02);
        thr_wr = 1'b1; tick(); thr_wr = 1'b0; tick();

        // R8 / R5 FIFO entry
        fifo_mode = 1'b1; tick(); tick();
        chk("R8 fifo entry", iir_rdata, 8'hC2);
        rx_timeout = 1'b1; tick();
        chk("R3 timeout", iir_rdata, 8'hCC);
        rx_ready = 1'b1; tick();
        chk("R3 data over timeout", iir_rdata, 8'hC4);
        rx_ready = 1'b0; fifo_mode = 1'b0; tick();
        chk("R5 timeout hidden", iir_rdata, 8'h02);

        // R4 gating
        wr_ier(8'h00);
        tick();
        chk("R4 all masked", iir_rdata, 8'h01);
        chk("R4 irq masked", {7'h0, irq}, 8'h00);
        rx_timeout = 1'b0; thr_wr = 1'b1; tick(); thr_wr = 1'b0; tick();

        // Random phase
        rd_left = 0;
        for (int i = 0; i < 4000; i++) begin
            ier_we       = ($urandom % 100) < 5;
            ier_wdata    = 8'($urandom);
            if (($urandom % 100) < 2)  fifo_mode = ~fifo_mode;
            if (($urandom % 100) < 5)  out2_en = ~out2_en;
            ls_event     = ($urandom % 100) < 5;
            ls_status_rd = ($urandom % 100) < 5;
            ms_event     = ($urandom % 100) < 5;
            ms_status_rd = ($urandom % 100) < 5;
            thr_wr       = ($urandom % 100) < 5;
            if (($urandom % 100) < 10) rx_ready = ~rx_ready;
            if (($urandom % 100) < 10) rx_timeout = ~rx_timeout;
            if (($urandom % 100) < 10) thr_empty = ~thr_empty;
            if (rd_left > 0) begin
                rd_left--;
                iir_rd = 1'b1;
            end else if (($urandom % 100) < 8) begin
                rd_left = int'($urandom % 4);
                iir_rd = 1'b1;
            end else begin
                iir_rd = 1'b0;
            end
            tick();
        end

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule